// File: doc/BRIEF.md
# Instrument Status Byte and Service Request Logic

This block gathers the status of a programmable instrument into one status byte and decides when the instrument asks its controller for service. It takes three sources. The first is a one-bit summary of questionable conditions. The second is a one-bit summary of operation conditions. The third is a standard event register that is held inside the block. This register latches event pulses and a power-on pulse, and a host-written enable mask reduces it to a one-bit event summary.

A host-written service request enable mask selects which status byte bits may call for service. The OR of the selected bits is the master summary. A rising edge of the master summary latches a request bit, and that bit drives the request interrupt line. The host issues one command per cycle through a small command port. There are five commands: write the event enable mask, read and clear the event register, write the service request enable mask, query the status byte without side effects, and serial poll. Bit 6 of the returned byte depends on the command. The query returns the live master summary in bit 6. The serial poll returns the latched request bit in bit 6 and then clears that bit.

Top module: `stat_srq_top`

## Requirements
- R1: Bit 3 of the status byte is `ques_sum_i`, bit 5 is the event summary and bit 7 is `oper_sum_i`. Bits 0, 1, 2 and 4 read 0.
- R2: Each bit of `evt_set_i` set in a cycle sets the same bit of the event register, and the bit stays set until a read-and-clear command (`cmd_op_i`=1). That command returns the register's value in `rd_data_o` on the next cycle and then clears the register.
- R3: The event summary is the OR of (event register AND event enable mask). Command 0 loads the enable mask from `cmd_data_i`.
- R4: A pulse on `pwr_on_i` sets bit 7 of the event register. If bit 7 is enabled, this path reaches the request line.
- R5: The query command (`cmd_op_i`=3) returns the status byte with the master summary in bit 6. It changes no state.
- R6: The request bit is set on the cycle after the master summary rises. `srq_o` equals the request bit. While the master summary stays high, no new request is made.
- R7: The serial poll command (`cmd_op_i`=4) returns the status byte with the request bit in bit 6 and then clears the request bit. If the master summary rises in the same cycle, the set wins.
- R8: Command 2 loads the service request enable mask. The master summary is the OR of (status byte AND that mask), and mask bit 6 is ignored.
- R9: An event that arrives in the same cycle as a read-and-clear is kept and appears in the next read.
- R10: After reset, the event register, both masks and the request bit are 0, and `srq_o` and `rd_valid_o` are low.
- R11: `rd_valid_o` is high for exactly the one cycle after commands 1, 3 and 4. Codes 5 to 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ques_sum_i | input | 1 | Questionable group summary |
| oper_sum_i | input | 1 | Operation group summary |
| evt_set_i | input | EVT_W | Event pulses into the event register |
| pwr_on_i | input | 1 | Power-on event pulse |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | DATA_W | Mask data for write commands |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | DATA_W | Read response data |
| srq_o | output | 1 | Service request line |

## Verification
Random cycles mix event pulses, summary toggles, mask writes and every command code. Each returned byte and the request line are compared with a reference model, and the comparison shows apart the wrong bit positions, mask use and clear timing. Directed sequences cover three cases. The first is a held master summary, which must not make a second request after a poll. The second is a fall followed by a rise, which must make one. The third is a poll on the same cycle as a rise. Further cases set only mask bit 6, send an event together with a clear, and enable a power-on request. Together these separate the edge-triggered request latch from a level copy, and keeping an event from dropping it.

// File: rtl/stat_srq_pkg.sv
package stat_srq_pkg;
   typedef enum logic [2:0] {
      OP_ESE_WR  = 3'd0,
      OP_EVT_RC  = 3'd1,
      OP_SRE_WR  = 3'd2,
      OP_STB_QRY = 3'd3,
      OP_POLL    = 3'd4
   } cmd_op_e;

   localparam int QUES_POS = 3;
   localparam int ESB_POS  = 5;
   localparam int RQS_POS  = 6;
   localparam int OPER_POS = 7;
   localparam int PON_POS  = 7;
endpackage

// File: rtl/std_evt_reg.sv
module std_evt_reg #(
   parameter int W       = 8,
   parameter int PON_BIT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         pon_i,
   input  logic         clr_i,
   input  logic         ena_we_i,
   input  logic [W-1:0] ena_d_i,
   output logic [W-1:0] evt_o,
   output logic         sum_o
);
   initial begin
      if (PON_BIT >= W || PON_BIT < 0) $error("PON_BIT outside event register");
   end

   logic [W-1:0] evt_q;
   logic [W-1:0] ena_q;

   for (genvar k = 0; k < W; k++) begin : g_bit
      logic set_k;
      if (k == PON_BIT) begin : g_pon
         assign set_k = set_i[k] | pon_i;
      end else begin : g_std
         assign set_k = set_i[k];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)     evt_q[k] <= 1'b0;
         else if (set_k) evt_q[k] <= 1'b1;
         else if (clr_i) evt_q[k] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        ena_q <= '0;
      else if (ena_we_i) ena_q <= ena_d_i;
   end

   assign evt_o = evt_q;
   assign sum_o = |(evt_q & ena_q);

   AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((evt_q & $past(set_i)) == $past(set_i))); // R9
   AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R2
   AST_PON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      pon_i |=> evt_q[PON_BIT]); // R4
endmodule

// File: rtl/stb_build.sv
module stb_build #(
   parameter int DATA_W = 8
) (
   input  logic              ques_i,
   input  logic              esb_i,
   input  logic              oper_i,
   input  logic [DATA_W-1:0] sre_i,
   output logic [DATA_W-1:0] stb_o,
   output logic              mss_o
);
   import stat_srq_pkg::*;

   initial begin
      if (DATA_W < 8) $error("DATA_W must hold a status byte");
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_stb
      if (b == QUES_POS) begin : g_q
         assign stb_o[b] = ques_i;
      end else if (b == ESB_POS) begin : g_e
         assign stb_o[b] = esb_i;
      end else if (b == OPER_POS) begin : g_o
         assign stb_o[b] = oper_i;
      end else begin : g_z
         assign stb_o[b] = 1'b0;
      end
   end

   assign mss_o = |(stb_o & sre_i);
endmodule

// File: rtl/srq_latch.sv
module srq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic mss_i,
   input  logic poll_i,
   output logic rqs_o
);
   logic mss_q;
   logic rqs_q;
   logic rise;

   assign rise = mss_i & ~mss_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mss_q <= 1'b0;
         rqs_q <= 1'b0;
      end else begin
         mss_q <= mss_i;
         if (rise)        rqs_q <= 1'b1;
         else if (poll_i) rqs_q <= 1'b0;
      end
   end

   assign rqs_o = rqs_q;

   AST_RQS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (rqs_q && !$past(rqs_q)) |-> ($past(mss_i) && !$past(mss_q))); // R6
   AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_i && !rise) |=> !rqs_q); // R7
endmodule

// File: rtl/stat_srq_top.sv
module stat_srq_top #(
   parameter int EVT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ques_sum_i,
   input  logic              oper_sum_i,
   input  logic [EVT_W-1:0]  evt_set_i,
   input  logic              pwr_on_i,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [DATA_W-1:0] cmd_data_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              srq_o
);
   import stat_srq_pkg::*;

   localparam logic [DATA_W-1:0] SRE_KEEP = ~(DATA_W'(1) << RQS_POS);

   initial begin
      if (EVT_W > DATA_W) $error("event register wider than data path");
      if (EVT_W <= PON_POS) $error("event register lacks power-on bit");
   end

   logic do_ese, do_rc, do_sre, do_qry, do_poll;
   assign do_ese  = cmd_valid_i && (cmd_op_i == OP_ESE_WR);
   assign do_rc   = cmd_valid_i && (cmd_op_i == OP_EVT_RC);
   assign do_sre  = cmd_valid_i && (cmd_op_i == OP_SRE_WR);
   assign do_qry  = cmd_valid_i && (cmd_op_i == OP_STB_QRY);
   assign do_poll = cmd_valid_i && (cmd_op_i == OP_POLL);

   logic [EVT_W-1:0]  evt;
   logic              esb;
   logic [DATA_W-1:0] sre_q;
   logic [DATA_W-1:0] stb;
   logic              mss;
   logic              rqs;

   std_evt_reg #(.W(EVT_W), .PON_BIT(PON_POS)) u_evt (
      .clk(clk), .rst_n(rst_n), .set_i(evt_set_i), .pon_i(pwr_on_i),
      .clr_i(do_rc), .ena_we_i(do_ese), .ena_d_i(cmd_data_i[EVT_W-1:0]),
      .evt_o(evt), .sum_o(esb));

   always_ff @(posedge clk) begin
      if (!rst_n)      sre_q <= '0;
      else if (do_sre) sre_q <= cmd_data_i & SRE_KEEP;
   end

   stb_build #(.DATA_W(DATA_W)) u_stb (
      .ques_i(ques_sum_i), .esb_i(esb), .oper_i(oper_sum_i),
      .sre_i(sre_q), .stb_o(stb), .mss_o(mss));

   srq_latch u_srq (
      .clk(clk), .rst_n(rst_n), .mss_i(mss), .poll_i(do_poll), .rqs_o(rqs));

   logic [DATA_W-1:0] rd_d;
   always_comb begin
      rd_d = '0;
      if (do_rc)        rd_d = DATA_W'(evt);
      else if (do_qry)  rd_d = stb | (DATA_W'(mss) << RQS_POS);
      else if (do_poll) rd_d = stb | (DATA_W'(rqs) << RQS_POS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= do_rc | do_qry | do_poll;
         rd_data_o  <= rd_d;
      end
   end

   assign srq_o = rqs;

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(do_rc || do_qry || do_poll)); // R11
   AST_QRY_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (do_qry && !(|evt_set_i) && !pwr_on_i) |=> $stable(evt)); // R5
   AST_SRE_BIT6: assert property (@(posedge clk) disable iff (!rst_n)
      !sre_q[RQS_POS]); // R8
endmodule

// File: tb/stat_srq_top_tb.sv
module stat_srq_top_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ques = 1'b0, oper = 1'b0, pon = 1'b0;
   logic [7:0] evset = '0;
   logic       cvalid = 1'b0;
   logic [2:0] cop = '0;
   logic [7:0] cdata = '0;
   logic       rd_valid, srq;
   logic [7:0] rd_data;

   int errors = 0;
   int checks = 0;

   logic [7:0] m_evt = '0, m_ese = '0, m_sre = '0;
   logic       m_mssq = 1'b0, m_rqs = 1'b0;
   logic       exp_v;
   logic [7:0] exp_d;
   string      exp_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   stat_srq_top u_dut (
      .clk(clk), .rst_n(rst_n), .ques_sum_i(ques), .oper_sum_i(oper),
      .evt_set_i(evset), .pwr_on_i(pon), .cmd_valid_i(cvalid),
      .cmd_op_i(cop), .cmd_data_i(cdata), .rd_valid_o(rd_valid),
      .rd_data_o(rd_data), .srq_o(srq));

   function automatic logic [7:0] stb_of(logic q, logic o, logic [7:0] e, logic [7:0] en);
      return {o, 1'b0, |(e & en), 1'b0, q, 3'b000};
   endfunction

   function automatic logic mss_of(logic [7:0] s, logic [7:0] sre);
      return |(s & sre & 8'hBF);
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // drive at negedge, model the clock edge, check after it
   task automatic step(logic q, logic o, logic [7:0] es, logic p,
                       logic v, logic [2:0] op, logic [7:0] d);
      logic [7:0] s;
      logic m;
      ques = q; oper = o; evset = es; pon = p; cvalid = v; cop = op; cdata = d;
      s = stb_of(q, o, m_evt, m_ese);
      m = mss_of(s, m_sre);
      exp_v = v && (op == 3'd1 || op == 3'd3 || op == 3'd4);
      exp_d = 8'h00;
      exp_tag = "R11";
      if (v && op == 3'd1) begin exp_d = m_evt; exp_tag = "R2/R9 event read"; end
      if (v && op == 3'd3) begin exp_d = s | {1'b0, m, 6'b0}; exp_tag = "R1/R5 query"; end
      if (v && op == 3'd4) begin exp_d = s | {1'b0, m_rqs, 6'b0}; exp_tag = "R7 poll"; end
      if (m && !m_mssq)              m_rqs = 1'b1;
      else if (v && op == 3'd4)      m_rqs = 1'b0;
      m_mssq = m;
      m_evt = ((v && op == 3'd1) ? 8'h00 : m_evt) | es | {p, 7'b0};
      if (v && op == 3'd0) m_ese = d;
      if (v && op == 3'd2) m_sre = d & 8'hBF;
      @(posedge clk);
      @(negedge clk);
      check("R11 rd_valid", {7'b0, rd_valid}, {7'b0, exp_v});
      if (exp_v) check(exp_tag, rd_data, exp_d);
      check("R6 srq", {7'b0, srq}, {7'b0, m_rqs});
   endtask

   task automatic idle(logic q, logic o);
      step(q, o, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R10 srq in reset", {7'b0, srq}, 8'h00);
      check("R10 rd_valid in reset", {7'b0, rd_valid}, 8'h00);
      rst_n = 1'b1;
      // reset state: event register and status byte empty
      step(0, 0, 8'h00, 0, 1, 3'd1, 8'h00);
      step(0, 0, 8'h00, 0, 1, 3'd3, 8'h00);

      // R1 bit positions with no masks
      step(1, 1, 8'h00, 0, 1, 3'd3, 8'h00);
      check("R1 bits 3 and 7", rd_data, 8'h88);

      // R4 power-on enabled gives a request
      step(0, 0, 8'h00, 0, 1, 3'd0, 8'h80);   // ese bit7
      step(0, 0, 8'h00, 0, 1, 3'd2, 8'h20);   // sre bit5
      step(0, 0, 8'h00, 1, 0, 3'd0, 8'h00);   // pon pulse
      idle(0, 0);
      check("R4 power-on request", {7'b0, srq}, 8'h01);
      // R6 held MSS: poll clears, no re-request
      step(0, 0, 8'h00, 0, 1, 3'd4, 8'h00);
      check("R7 poll sees RQS", rd_data, 8'h60);
      idle(0, 0); idle(0, 0);
      check("R6 no re-request while held", {7'b0, srq}, 8'h00);
      // R3/R2 clear event, MSS falls, new event rises again
      step(0, 0, 8'h00, 0, 1, 3'd1, 8'h00);
      check("R2 read returns pon bit", rd_data, 8'h80);
      idle(0, 0);
      step(0, 0, 8'h00, 1, 0, 3'd0, 8'h00);
      idle(0, 0);
      check("R6 new request after fall and rise", {7'b0, srq}, 8'h01);

      // R9 event with clear is kept
      step(0, 0, 8'h04, 0, 1, 3'd1, 8'h00);
      step(0, 0, 8'h00, 0, 1, 3'd1, 8'h00);
      check("R9 kept event", rd_data, 8'h04);

      // R8 only sre bit 6: never a request
      step(0, 0, 8'h00, 0, 1, 3'd4, 8'h00);
      step(0, 0, 8'h00, 0, 1, 3'd2, 8'h40);
      step(1, 1, 8'h00, 0, 0, 3'd0, 8'h00);
      step(1, 1, 8'h00, 0, 1, 3'd3, 8'h00);
      check("R8 bit6 ignored", rd_data, 8'h88);
      // R7 poll same cycle as rising MSS: set wins
      step(0, 0, 8'h00, 0, 1, 3'd2, 8'h08);
      step(1, 0, 8'h00, 0, 1, 3'd4, 8'h00);
      check("R7 rise beats poll", {7'b0, srq}, 8'h01);
      // R11 unused codes do nothing
      step(1, 0, 8'h00, 0, 1, 3'd6, 8'hFF);
      step(1, 0, 8'h00, 0, 1, 3'd3, 8'h00);
      check("R11 ignored code kept masks", rd_data, 8'h48);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         step(r[0], r[1], (r[4:2] == 3'd0) ? r[15:8] : 8'h00, r[5] & r[6] & r[7],
              r[16] | r[17], r[20:18], r[31:24]);
      end
      finish_run();
   end
endmodule